// File: doc/BRIEF.md
# Display Adapter Register Window Decoder

This block is the slave side of a 4 KB memory-mapped register window on a display adapter. A host issues single-beat reads and writes. Each access has a 12-bit byte offset, 32-bit data and a size of byte, word or dword. The decoder sends the access to one of four regions:

- a 1 KB store holding the monitor identification (EDID) blob;
- a window onto the legacy byte-wide indexed display I/O ports, reached through a sequential byte-port bus;
- a flat bank of 16-bit mode-setting registers;
- a pair of 32-bit extended registers, one of which selects framebuffer byte order.

All host data is right-justified. The byte at the access offset sits in `host_wdata[7:0]` and `host_rdata[7:0]`, the next byte sits above it, and any unused upper lanes read as zero. The host raises `host_req` and holds every request field stable until `host_done` pulses for one cycle. In that pulse cycle `host_rdata` carries the read result, and it is zero for writes. The EDID store is filled through a separate side load port. The port bus uses a valid/ready handshake, and `pt_rdata` is taken in the cycle of the handshake.

Top module: `disp_mmio_decoder`

## Requirements
- R1: After reset, `host_done`, `pt_valid` and `fb_big_endian` are low, the byte-order register reads 0x1E1E1E1E, and every mode register reads zero.
- R2: Offsets 0x000–0x3FF read the EDID store at byte, word or dword size, low byte first. The store is written only through the side load port, and host writes there leave its contents unchanged.
- R3: A byte access at offset 0x400+k (k in 0..31) makes exactly one port-bus cycle at port 0x3C0+k. A write drives the byte, and a read returns the byte accepted from the port side.
- R4: A word access at an even window offset makes two port cycles in ascending port order, the lower port (index) first. A dword access makes four such cycles. `host_done` rises only after the last cycle is accepted, and read bytes are assembled with the first cycle's byte in the low lane.
- R5: Mode register n (n = 0..10) is at offset 0x500 + 2n. A word write stores 16 bits that a word read returns.
- R6: A byte write to the mode bank changes only the addressed byte of one register. A dword access at a 4-aligned offset covers registers n and n+1, with register n in the low half.
- R7: A word access to the mode bank at an odd offset, or a dword access that is not 4-aligned, writes nothing and reads zero.
- R8: The dword at 0x600 always reads 8, and writes to it have no effect.
- R9: The dword at 0x604 holds the framebuffer byte order. It accepts only a full dword write of 0xBEBEBEBE (big endian, `fb_big_endian` = 1) or 0x1E1E1E1E (little endian, `fb_big_endian` = 0). Any other value and any narrower write leave it unchanged.
- R10: Offsets 0x420–0x4FF, 0x516–0x5FF and 0x608–0xFFF read zero. Writes there change no register and make no port cycle. A mode dword at 0x514 returns register 10 in the low half and zero above it.
- R11: An access to any region other than the port window completes with `host_done` high in the cycle right after the one in which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte offset in the window |
| host_size | input | 2 | 0 = byte, 1 = word, 2 = dword |
| host_wdata | input | 32 | Write data, right-justified |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_done` |
| edid_ld_en | input | 1 | Side load strobe for the EDID store |
| edid_ld_addr | input | 10 | Side load byte address |
| edid_ld_data | input | 8 | Side load byte |
| pt_valid | output | 1 | Port cycle pending |
| pt_we | output | 1 | Port cycle is a write |
| pt_addr | output | 10 | I/O port number |
| pt_wdata | output | 8 | Port write byte |
| pt_ready | input | 1 | Port side accepts the cycle |
| pt_rdata | input | 8 | Port read byte, valid with `pt_ready` |
| fb_big_endian | output | 1 | Framebuffer is big endian |

## Verification
The assertions assume the host holds `host_req` and every request field steady from raising the request until `host_done`. They also assume `host_size` is never 3, and that word and dword accesses to the EDID store and the port window are naturally aligned. On the port side they assume `pt_rdata` is meaningful only when `pt_ready` is high. The driver task in the bench raises one request at a time, changes nothing until it sees the completion pulse, and uses only aligned sizes outside the mode bank. Misaligned offsets go only into the mode bank, where R7 defines what they do. The port responder answers after a delay of zero, one or two cycles, so the assertions that ports stay stable and step upward are exercised under back-pressure.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_EDID,
        RG_PORT,
        RG_MODE,
        RG_EXT,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PORT,
        ST_DONE
    } host_state_e;

    localparam logic [11:0] PORT_WIN_BASE  = 12'h400;
    localparam int          PORT_WIN_BYTES = 32;
    localparam logic [11:0] MODE_BASE      = 12'h500;
    localparam logic [11:0] EXT_BASE       = 12'h600;
    localparam int          EXT_BYTES      = 8;
    localparam logic [31:0] ORDER_BIG      = 32'hBEBE_BEBE;
    localparam logic [31:0] ORDER_LITTLE   = 32'h1E1E_1E1E;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmw_edid_store.sv
module dmw_edid_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [2:0]    rd_nbytes,
    output logic [31:0]   rd_data
);
    // Byte-wide store; only the side port writes it.
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem_q[ld_addr] <= ld_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < int'(rd_nbytes)) begin
                rd_data[8*j +: 8] = mem_q[rd_addr + AW'(j)];
            end
        end
    end
endmodule

// File: rtl/dmw_port_seq.sv
module dmw_port_seq #(
    parameter logic [9:0] PORT_BASE = 10'h3C0,
    parameter int WIN_BYTES = 32,
    localparam int OW = $clog2(WIN_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [OW-1:0] start_off,
    input  logic [2:0]    start_nbytes,
    input  logic [31:0]   start_wdata,
    output logic          done,
    output logic [31:0]   rdata,
    output logic          pt_valid,
    output logic          pt_we,
    output logic [9:0]    pt_addr,
    output logic [7:0]    pt_wdata,
    input  logic          pt_ready,
    input  logic [7:0]    pt_rdata
);
    typedef struct packed {
        logic          active;
        logic          we;
        logic [OW-1:0] off;
        logic [1:0]    idx;
        logic [1:0]    last;
        logic [31:0]   wdata;
        logic [31:0]   rdata;
        logic          done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (start) begin
            seq_d.active = 1'b1;
            seq_d.we     = start_we;
            seq_d.off    = start_off;
            seq_d.idx    = 2'd0;
            seq_d.last   = 2'(start_nbytes - 3'd1);
            seq_d.wdata  = start_wdata;
            seq_d.rdata  = '0;
        end else if (seq_q.active && pt_ready) begin
            if (!seq_q.we) begin
                seq_d.rdata[8*seq_q.idx +: 8] = pt_rdata;
            end
            if (seq_q.idx == seq_q.last) begin
                seq_d.active = 1'b0;
                seq_d.done   = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pt_valid = seq_q.active;
    assign pt_we    = seq_q.we;
    assign pt_addr  = PORT_BASE + 10'(seq_q.off) + 10'(seq_q.idx);
    assign pt_wdata = seq_q.wdata[8*seq_q.idx +: 8];
    assign done     = seq_q.done;
    assign rdata    = seq_q.rdata;
endmodule

// File: rtl/dmw_mode_regs.sv
module dmw_mode_regs #(
    parameter int NREG = 11,
    parameter int OFF_W = 8,
    localparam int NBYTE = 2 * NREG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       nbytes,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_data
);
    // Register n occupies bytes 2n (low) and 2n+1 (high).
    logic [8*NBYTE-1:0] bank_d, bank_q;
    logic               align_ok;

    always_comb begin
        case (nbytes)
            3'd2:    align_ok = !off[0];
            3'd4:    align_ok = (off[1:0] == 2'b00);
            default: align_ok = 1'b1;
        endcase
    end

    always_comb begin
        bank_d  = bank_q;
        rd_data = '0;
        for (int j = 0; j < 4; j++) begin
            int b;
            b = int'(off) + j;
            if (align_ok && (j < int'(nbytes)) && (b < NBYTE)) begin
                rd_data[8*j +: 8] = bank_q[8*b +: 8];
                if (wr_en) begin
                    bank_d[8*b +: 8] = wdata[8*j +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/dmw_ext_regs.sv
module dmw_ext_regs
    import dmw_pkg::*;
#(
    parameter logic [31:0] REGION_SIZE = 32'd8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  off,
    input  logic [2:0]  nbytes,
    input  logic [31:0] wdata,
    output logic [31:0] rd_data,
    output logic        big_endian
);
    logic [31:0] order_d, order_q;
    logic [31:0] word;
    logic [31:0] shifted;

    always_comb begin
        order_d = order_q;
        if (wr_en && (off == 3'd4) && (nbytes == 3'd4) &&
            ((wdata == ORDER_BIG) || (wdata == ORDER_LITTLE))) begin
            order_d = wdata;
        end
    end

    always_comb begin
        word    = off[2] ? order_q : REGION_SIZE;
        shifted = word >> (8 * off[1:0]);
        rd_data = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < int'(nbytes)) begin
                rd_data[8*j +: 8] = shifted[8*j +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORDER_LITTLE;
        end else begin
            order_q <= order_d;
        end
    end

    assign big_endian = (order_q == ORDER_BIG);
endmodule

// File: rtl/disp_mmio_decoder.sv
module disp_mmio_decoder
    import dmw_pkg::*;
#(
    parameter int         EDID_BYTES = 1024,
    parameter int         MODE_REGS  = 11,
    parameter logic [9:0] PORT_BASE  = 10'h3C0,
    localparam int        EDID_AW    = $clog2(EDID_BYTES),
    localparam int        PORT_OW    = $clog2(PORT_WIN_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [11:0]        host_addr,
    input  logic [1:0]         host_size,
    input  logic [31:0]        host_wdata,
    output logic               host_done,
    output logic [31:0]        host_rdata,
    input  logic               edid_ld_en,
    input  logic [EDID_AW-1:0] edid_ld_addr,
    input  logic [7:0]         edid_ld_data,
    output logic               pt_valid,
    output logic               pt_we,
    output logic [9:0]         pt_addr,
    output logic [7:0]         pt_wdata,
    input  logic               pt_ready,
    input  logic [7:0]         pt_rdata,
    output logic               fb_big_endian
);
    localparam logic [11:0] PORT_END = 12'(int'(PORT_WIN_BASE) + PORT_WIN_BYTES);
    localparam logic [11:0] MODE_END = 12'(int'(MODE_BASE) + 2 * MODE_REGS);
    localparam logic [11:0] EXT_END  = 12'(int'(EXT_BASE) + EXT_BYTES);

    typedef struct packed {
        host_state_e state;
        logic [31:0] rdata;
    } host_s;

    host_s       host_d, host_q;
    region_e     region;
    logic [2:0]  nbytes;
    logic        accept;
    logic [31:0] edid_rd, mode_rd, ext_rd, seq_rd;
    logic        seq_done;

    always_comb begin
        if (int'(host_addr) < EDID_BYTES) begin
            region = RG_EDID;
        end else if (host_addr >= PORT_WIN_BASE && host_addr < PORT_END) begin
            region = RG_PORT;
        end else if (host_addr >= MODE_BASE && host_addr < MODE_END) begin
            region = RG_MODE;
        end else if (host_addr >= EXT_BASE && host_addr < EXT_END) begin
            region = RG_EXT;
        end else begin
            region = RG_NONE;
        end
    end

    assign nbytes = size_bytes(host_size);
    assign accept = (host_q.state == ST_IDLE) && host_req;

    dmw_edid_store #(.DEPTH(EDID_BYTES)) edid_i (
        .clk      (clk),
        .ld_en    (edid_ld_en),
        .ld_addr  (edid_ld_addr),
        .ld_data  (edid_ld_data),
        .rd_addr  (host_addr[EDID_AW-1:0]),
        .rd_nbytes(nbytes),
        .rd_data  (edid_rd)
    );

    dmw_port_seq #(.PORT_BASE(PORT_BASE), .WIN_BYTES(PORT_WIN_BYTES)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept && (region == RG_PORT)),
        .start_we    (host_we),
        .start_off   (host_addr[PORT_OW-1:0]),
        .start_nbytes(nbytes),
        .start_wdata (host_wdata),
        .done        (seq_done),
        .rdata       (seq_rd),
        .pt_valid    (pt_valid),
        .pt_we       (pt_we),
        .pt_addr     (pt_addr),
        .pt_wdata    (pt_wdata),
        .pt_ready    (pt_ready),
        .pt_rdata    (pt_rdata)
    );

    dmw_mode_regs #(.NREG(MODE_REGS), .OFF_W(8)) mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept && host_we && (region == RG_MODE)),
        .off    (host_addr[7:0]),
        .nbytes (nbytes),
        .wdata  (host_wdata),
        .rd_data(mode_rd)
    );

    dmw_ext_regs #(.REGION_SIZE(32'(EXT_BYTES))) ext_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept && host_we && (region == RG_EXT)),
        .off       (host_addr[2:0]),
        .nbytes    (nbytes),
        .wdata     (host_wdata),
        .rd_data   (ext_rd),
        .big_endian(fb_big_endian)
    );

    always_comb begin
        host_d = host_q;
        case (host_q.state)
            ST_IDLE: begin
                if (host_req) begin
                    host_d.rdata = '0;
                    if (region == RG_PORT) begin
                        host_d.state = ST_PORT;
                    end else begin
                        host_d.state = ST_DONE;
                        if (!host_we) begin
                            case (region)
                                RG_EDID: host_d.rdata = edid_rd;
                                RG_MODE: host_d.rdata = mode_rd;
                                RG_EXT:  host_d.rdata = ext_rd;
                                default: host_d.rdata = '0;
                            endcase
                        end
                    end
                end
            end
            ST_PORT: begin
                if (seq_done) begin
                    host_d.state = ST_DONE;
                    host_d.rdata = host_we ? '0 : seq_rd;
                end
            end
            default: begin
                host_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q.state <= ST_IDLE;
            host_q.rdata <= '0;
        end else begin
            host_q <= host_d;
        end
    end

    assign host_done  = (host_q.state == ST_DONE);
    assign host_rdata = host_q.rdata;
endmodule

// File: rtl/dmw_checker.sv
module dmw_checker #(
    parameter logic [9:0] PORT_BASE = 10'h3C0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic [1:0] host_size,
    input logic       host_done,
    input logic       pt_valid,
    input logic       pt_ready,
    input logic       pt_we,
    input logic [9:0] pt_addr,
    input logic [7:0] pt_wdata,
    input logic       fb_big_endian
);
    // Input assumption: the reserved size code is never used.
    a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> (host_size != 2'b11));

    // R3: port cycles stay inside the legacy port range.
    a_r3_port_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> ((pt_addr >= PORT_BASE) && (pt_addr <= PORT_BASE + 10'd31)));

    // R4: a pending port cycle holds until accepted.
    a_r4_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && !pt_ready) |=>
            (pt_valid && $stable(pt_addr) && $stable(pt_we) && $stable(pt_wdata)));

    // R4: consecutive cycles of one access walk upward by one port.
    a_r4_port_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && pt_ready) |=> (!pt_valid || (pt_addr == $past(pt_addr) + 10'd1)));

    // R4: port cycles occur only inside a host access.
    a_r4_port_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> host_req);

    // R11: completion is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R9: byte order changes only as a write completes.
    a_r9_order_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_big_endian) |-> host_done);
endmodule

bind disp_mmio_decoder dmw_checker #(.PORT_BASE(PORT_BASE)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_size    (host_size),
    .host_done    (host_done),
    .pt_valid     (pt_valid),
    .pt_ready     (pt_ready),
    .pt_we        (pt_we),
    .pt_addr      (pt_addr),
    .pt_wdata     (pt_wdata),
    .fb_big_endian(fb_big_endian)
);

// File: tb/disp_mmio_decoder_tb_top.sv
`timescale 1ns/1ps
module disp_mmio_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_we;
    logic [11:0] host_addr;
    logic [1:0]  host_size;
    logic [31:0] host_wdata;
    logic        host_done;
    logic [31:0] host_rdata;
    logic        edid_ld_en;
    logic [9:0]  edid_ld_addr;
    logic [7:0]  edid_ld_data;
    logic        pt_valid, pt_we, pt_ready;
    logic [9:0]  pt_addr;
    logic [7:0]  pt_wdata, pt_rdata;
    logic        fb_big_endian;

    always #4 clk = ~clk;

    disp_mmio_decoder dut_i (.*);

    typedef struct {
        logic [31:0] exp;
        bit          chk;
        string       tag;
    } sb_item_t;

    typedef struct {
        logic [9:0] addr;
        logic       we;
        logic [7:0] data;
    } pcyc_t;

    sb_item_t sb_q[$];
    pcyc_t    plog[$];
    int       n_chk = 0;
    int       n_bad = 0;
    bit       finished = 0;

    function automatic logic [7:0] edid_pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] port_model(input logic [9:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Port-side responder: answers after 0, 1 or 2 idle cycles.
    initial begin
        int wcnt;
        int nextw;
        wcnt     = 0;
        nextw    = 1;
        pt_ready = 1'b0;
        pt_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (pt_ready) begin
                pt_ready = 1'b0;
            end else if (rst_n && pt_valid) begin
                if (wcnt == 0) begin
                    pt_ready = 1'b1;
                    pt_rdata = port_model(pt_addr);
                    plog.push_back('{pt_addr, pt_we, pt_wdata});
                    wcnt  = nextw;
                    nextw = (nextw + 1) % 3;
                end else begin
                    wcnt--;
                end
            end
        end
    end

    // Monitor: pops one scoreboard item per completion.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && host_done) begin
                if (sb_q.size() == 0) begin
                    check_eq("R11 unexpected completion", 32'h1, 32'h0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (it.chk) check_eq(it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    // Driver: one access, held until completion.
    task automatic do_acc(input logic we, input logic [11:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        int  lat;
        bit  is_port;
        is_port = (addr >= 12'h400) && (addr < 12'h420);
        plog.delete();
        sb_q.push_back('{exp, !we, tag});
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = addr;
        host_size  = sz;
        host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_done && lat < 1000);
        host_req = 1'b0;
        if (!is_port) begin
            check_eq({"R11 latency ", tag}, 32'(lat), 32'd1);
            check_eq({"R10 no port cycle ", tag}, 32'(plog.size()), 32'd0);
        end else begin
            int beats;
            beats = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            check_eq({"R4 beats at completion ", tag}, 32'(plog.size()), 32'(beats));
        end
    endtask

    task automatic chk_pcyc(input int i, input logic [9:0] a, input logic we,
                            input logic [7:0] d, input string tag);
        if (i >= plog.size()) begin
            check_eq({tag, " missing port cycle"}, 32'(plog.size()), 32'(i + 1));
        end else begin
            check_eq({tag, " port addr"}, 32'(plog[i].addr), 32'(a));
            check_eq({tag, " port dir"}, 32'(plog[i].we), 32'(we));
            if (we) check_eq({tag, " port data"}, 32'(plog[i].data), 32'(d));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_size = '0; host_wdata = '0;
        edid_ld_en = 1'b0; edid_ld_addr = '0; edid_ld_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check_eq("R1 host_done", 32'(host_done), 32'd0);
        check_eq("R1 pt_valid", 32'(pt_valid), 32'd0);
        check_eq("R1 fb_big_endian", 32'(fb_big_endian), 32'd0);
        do_acc(1'b0, 12'h604, 2'd2, 32'h0, 32'h1E1E1E1E, "R1 R9 order reset");
        do_acc(1'b0, 12'h500, 2'd1, 32'h0, 32'h0, "R1 mode reg0 reset");
        do_acc(1'b0, 12'h514, 2'd1, 32'h0, 32'h0, "R1 mode reg10 reset");

        // R2: EDID side load and host reads
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            edid_ld_en = 1'b1; edid_ld_addr = 10'(i); edid_ld_data = edid_pat(i);
        end
        @(negedge clk);
        edid_ld_en = 1'b0;
        do_acc(1'b0, 12'h005, 2'd0, 32'h0, {24'h0, edid_pat(5)}, "R2 edid byte");
        do_acc(1'b0, 12'h102, 2'd1, 32'h0, {16'h0, edid_pat(259), edid_pat(258)}, "R2 edid word");
        do_acc(1'b0, 12'h3FC, 2'd2, 32'h0,
               {edid_pat(1023), edid_pat(1022), edid_pat(1021), edid_pat(1020)}, "R2 edid dword top");
        do_acc(1'b1, 12'h010, 2'd2, 32'hDEADBEEF, 32'h0, "R2 edid host write");
        do_acc(1'b0, 12'h010, 2'd2, 32'h0,
               {edid_pat(19), edid_pat(18), edid_pat(17), edid_pat(16)}, "R2 edid write ignored");

        // R3: single port cycles
        do_acc(1'b1, 12'h405, 2'd0, 32'h000000A7, 32'h0, "R3 port byte write");
        chk_pcyc(0, 10'h3C5, 1'b1, 8'hA7, "R3 byte write");
        do_acc(1'b0, 12'h40A, 2'd0, 32'h0, {24'h0, port_model(10'h3CA)}, "R3 port byte read");
        chk_pcyc(0, 10'h3CA, 1'b0, 8'h00, "R3 byte read");

        // R4: split word and dword port accesses
        do_acc(1'b1, 12'h404, 2'd1, 32'h00001234, 32'h0, "R4 port word write");
        chk_pcyc(0, 10'h3C4, 1'b1, 8'h34, "R4 index first");
        chk_pcyc(1, 10'h3C5, 1'b1, 8'h12, "R4 data second");
        do_acc(1'b0, 12'h414, 2'd1, 32'h0,
               {16'h0, port_model(10'h3D5), port_model(10'h3D4)}, "R4 port word read");
        chk_pcyc(0, 10'h3D4, 1'b0, 8'h00, "R4 word read first");
        do_acc(1'b0, 12'h418, 2'd2, 32'h0,
               {port_model(10'h3DB), port_model(10'h3DA), port_model(10'h3D9), port_model(10'h3D8)},
               "R4 port dword read");
        chk_pcyc(3, 10'h3DB, 1'b0, 8'h00, "R4 dword last");

        // R5: mode registers by word
        do_acc(1'b1, 12'h506, 2'd1, 32'h0000BEEF, 32'h0, "R5 write reg3");
        do_acc(1'b0, 12'h506, 2'd1, 32'h0, 32'h0000BEEF, "R5 read reg3");
        do_acc(1'b1, 12'h514, 2'd1, 32'h00001357, 32'h0, "R5 write reg10");
        do_acc(1'b0, 12'h514, 2'd1, 32'h0, 32'h00001357, "R5 read reg10");

        // R6: byte lanes and dword pairs
        do_acc(1'b1, 12'h507, 2'd0, 32'h00000055, 32'h0, "R6 byte write high lane");
        do_acc(1'b0, 12'h506, 2'd1, 32'h0, 32'h000055EF, "R6 byte lane only");
        do_acc(1'b1, 12'h508, 2'd2, 32'hAAAA5555, 32'h0, "R6 dword write");
        do_acc(1'b0, 12'h508, 2'd1, 32'h0, 32'h00005555, "R6 dword low reg4");
        do_acc(1'b0, 12'h50A, 2'd1, 32'h0, 32'h0000AAAA, "R6 dword high reg5");
        do_acc(1'b0, 12'h504, 2'd2, 32'h0, 32'h55EF0000, "R6 dword read reg2 reg3");

        // R7: misaligned mode accesses
        do_acc(1'b1, 12'h503, 2'd1, 32'h0000FFFF, 32'h0, "R7 odd word write");
        do_acc(1'b0, 12'h502, 2'd1, 32'h0, 32'h0, "R7 reg1 untouched");
        do_acc(1'b0, 12'h504, 2'd1, 32'h0, 32'h0, "R7 reg2 untouched");
        do_acc(1'b0, 12'h507, 2'd1, 32'h0, 32'h0, "R7 odd word read zero");
        do_acc(1'b0, 12'h506, 2'd2, 32'h0, 32'h0, "R7 unaligned dword read zero");

        // R8: region size register
        do_acc(1'b0, 12'h600, 2'd2, 32'h0, 32'd8, "R8 size read");
        do_acc(1'b1, 12'h600, 2'd2, 32'h12345678, 32'h0, "R8 size write");
        do_acc(1'b0, 12'h600, 2'd2, 32'h0, 32'd8, "R8 size unchanged");

        // R9: byte order register
        do_acc(1'b1, 12'h604, 2'd2, 32'hBEBEBEBE, 32'h0, "R9 set big");
        check_eq("R9 big flag", 32'(fb_big_endian), 32'd1);
        do_acc(1'b0, 12'h604, 2'd2, 32'h0, 32'hBEBEBEBE, "R9 read big");
        do_acc(1'b1, 12'h604, 2'd2, 32'h12345678, 32'h0, "R9 illegal value");
        do_acc(1'b0, 12'h604, 2'd2, 32'h0, 32'hBEBEBEBE, "R9 illegal ignored");
        do_acc(1'b1, 12'h604, 2'd1, 32'h00001E1E, 32'h0, "R9 narrow write");
        do_acc(1'b0, 12'h604, 2'd2, 32'h0, 32'hBEBEBEBE, "R9 narrow ignored");
        check_eq("R9 big flag held", 32'(fb_big_endian), 32'd1);
        do_acc(1'b1, 12'h604, 2'd2, 32'h1E1E1E1E, 32'h0, "R9 set little");
        check_eq("R9 little flag", 32'(fb_big_endian), 32'd0);

        // R10: unmapped holes
        do_acc(1'b0, 12'h420, 2'd2, 32'h0, 32'h0, "R10 read 0x420");
        do_acc(1'b1, 12'h430, 2'd0, 32'h000000FF, 32'h0, "R10 write 0x430");
        do_acc(1'b1, 12'h516, 2'd1, 32'h0000FFFF, 32'h0, "R10 write 0x516");
        do_acc(1'b0, 12'h514, 2'd2, 32'h0, 32'h00001357, "R10 reg10 dword tail");
        do_acc(1'b0, 12'h516, 2'd1, 32'h0, 32'h0, "R10 read 0x516");
        do_acc(1'b1, 12'h700, 2'd2, 32'hCAFEF00D, 32'h0, "R10 write 0x700");
        do_acc(1'b0, 12'h700, 2'd2, 32'h0, 32'h0, "R10 read 0x700");
        do_acc(1'b0, 12'hFFC, 2'd2, 32'h0, 32'h0, "R10 read 0xFFC");

        repeat (3) @(negedge clk);
        check_eq("R11 scoreboard drained", 32'(sb_q.size()), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule